// File: doc/BRIEF.md
# Sequential 8-bit Multiply/Divide Unit

This unit takes two unsigned operand bytes, called A and B, and runs either a multiply or a divide over several clock cycles. A one-cycle start pulse together with an operation select begins the work. The unit then reports new A and B values and a set of flags: carry, overflow and parity. The multiply produces a 16-bit product and splits it across the two bytes. The divide leaves the quotient in A and the remainder in B.

Both operations process two operand bits per clock. The multiply uses a radix-4 shift-add step and the divide uses two chained restoring shift-subtract stages. The data width and the number of bits per step are parameters, and the latency is derived from them. With the default values (8 bits wide, 2 bits per step) the latency is four cycles. A core uses the unit by pulsing start and waiting for the one-cycle done strobe. It then copies the presented values back into its A, B and flag registers.

Top module: `md8_unit`

## Requirements
- R1: With `op_div`=0 (multiply), the cycle in which `done` is high shows the upper byte of the product A*B on `b_out` and the lower byte on `a_out`.
- R2: With `op_div`=1 (divide) and B nonzero, the cycle in which `done` is high shows the integer quotient A/B on `a_out` and the remainder on `b_out`.
- R3: After every operation, `cy_out` is 0.
- R4: After a multiply, `ov_out` is 1 exactly when the product is greater than 255, which means the upper byte is nonzero.
- R5: After a divide, `ov_out` is 1 when B was zero and 0 otherwise. For a zero divisor the values on `a_out` and `b_out` are unspecified.
- R6: `par_out` is the XOR of all bits of `a_out` at every cycle, so it is 1 when `a_out` holds an odd number of ones.
- R7: A start is accepted only while `busy` is low. `busy` is then high for the next four cycles counted from that edge, minus the final one. `done` is high for exactly one cycle, the fourth cycle after the cycle in which start was sampled. `busy` is low in that cycle.
- R8: A start pulse that arrives while `busy` is high is ignored. It changes neither the operands, nor the operation, nor the time at which `done` appears.
- R9: After reset, `busy`, `done`, `a_out`, `b_out`, `cy_out`, `ov_out` and `par_out` are all 0.
- R10: After `done`, the values on `a_out`, `b_out`, `ov_out` and `cy_out` stay unchanged until the next start is accepted. A start may be accepted in the same cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, sampled on the rising edge |
| op_div | input | 1 | Operation select: 0 = multiply, 1 = divide |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle strobe that marks valid results |
| a_out | output | 8 | New A value (low product byte or quotient) |
| b_out | output | 8 | New B value (high product byte or remainder) |
| cy_out | output | 1 | Carry flag result, always cleared |
| ov_out | output | 1 | Overflow flag result |
| par_out | output | 1 | Parity of `a_out` |

## Verification
The embedded assertions cover the control behaviour on every cycle:
- the single-cycle `done` pulse;
- the step counter advancing by exactly one while busy, even when start is pulsed;
- results and flags staying still while the unit is idle;
- the cleared carry at completion;
- the link between the multiply overflow and the upper product byte.

The arithmetic itself can only be shown by the bench's scenarios. These compare the product, quotient and remainder against a behavioural model. They cover boundary operands (zero, 0xFF times 0xFF, a product of exactly 256, a divisor larger than the dividend, a zero divisor), a back-to-back start in the done cycle, and a start issued mid-operation.

// File: rtl/md8_pkg.sv
package md8_pkg;
   typedef enum logic {
      OP_MUL = 1'b0,
      OP_DIV = 1'b1
   } md_op_e;
endpackage

// File: rtl/md8_mul_step.sv
// One radix-2^S shift-add multiply step over a packed {acc, multiplier} word.
module md8_mul_step #(
   parameter int W = 8,
   parameter int S = 2
) (
   input  logic [2*W-1:0] w_in,
   input  logic [W-1:0]   mcand,
   output logic [2*W-1:0] w_out
);
   logic [W+S-1:0] part;
   logic [W+S-1:0] sum;

   always_comb begin
      part  = {{S{1'b0}}, mcand} * {{W{1'b0}}, w_in[S-1:0]};
      sum   = {{S{1'b0}}, w_in[2*W-1:W]} + part;
      w_out = {sum, w_in[W-1:S]};
   end
endmodule

// File: rtl/md8_div_step.sv
// S chained restoring shift-subtract stages over a packed {rem, quotient} word.
module md8_div_step #(
   parameter int W = 8,
   parameter int S = 2
) (
   input  logic [2*W-1:0] w_in,
   input  logic [W-1:0]   dvsr,
   output logic [2*W-1:0] w_out
);
   logic [2*W-1:0] stage [S+1];

   assign stage[0] = w_in;

   for (genvar k = 0; k < S; k++) begin : g_sub
      logic [W:0] trial;
      logic       fits;
      logic [W:0] rem;
      always_comb begin
         trial = {stage[k][2*W-1:W], stage[k][W-1]};
         fits  = (trial >= {1'b0, dvsr});
         rem   = fits ? (trial - {1'b0, dvsr}) : trial;
      end
      assign stage[k+1] = {rem[W-1:0], stage[k][W-2:0], fits};
   end

   assign w_out = stage[S];
endmodule

// File: rtl/md8_ctrl.sv
// Sequencer: accepts a launch when idle, counts LAT steps, pulses done.
module md8_ctrl #(
   parameter int LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic adv,
   output logic last,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(LAT + 1);

   logic [CW-1:0] cnt;

   assign load = start & ~busy;
   assign adv  = load | busy;
   assign last = busy & (cnt == CW'(LAT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (load) begin
            busy <= 1'b1;
            cnt  <= CW'(1);
         end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (busy) begin
            cnt  <= cnt + CW'(1);
         end
      end
   end

   // R7: done lasts a single cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: the step count never passes the last step while busy
   p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt != '0) && (cnt <= CW'(LAT - 1)));

   // R8: a start seen mid-operation does not restart the count
   p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy && (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/md8_unit.sv
module md8_unit #(
   parameter int W    = 8,
   parameter int STEP = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         op_div,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] a_out,
   output logic [W-1:0] b_out,
   output logic         cy_out,
   output logic         ov_out,
   output logic         par_out
);
   import md8_pkg::*;

   localparam int LAT = W / STEP;

   if ((W % STEP) != 0) begin : g_bad_step
      $error("md8_unit: W must be a multiple of STEP");
   end
   if (LAT < 2) begin : g_bad_lat
      $error("md8_unit: latency W/STEP must be at least 2");
   end

   logic           load, adv, last;
   logic [2*W-1:0] work, cur_work, mul_w, div_w, nxt_work;
   logic [W-1:0]   opnd, cur_opnd;
   md_op_e         op_q, cur_op;
   logic           ov_q, cy_q;

   md8_ctrl #(.LAT(LAT)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .adv   (adv),
      .last  (last),
      .busy  (busy),
      .done  (done)
   );

   always_comb begin
      cur_op   = load ? md_op_e'(op_div) : op_q;
      cur_work = load ? {{W{1'b0}}, (op_div ? a_in : b_in)} : work;
      cur_opnd = load ? (op_div ? b_in : a_in) : opnd;
   end

   md8_mul_step #(.W(W), .S(STEP)) u_mul (
      .w_in  (cur_work),
      .mcand (cur_opnd),
      .w_out (mul_w)
   );

   md8_div_step #(.W(W), .S(STEP)) u_div (
      .w_in  (cur_work),
      .dvsr  (cur_opnd),
      .w_out (div_w)
   );

   assign nxt_work = (cur_op == OP_DIV) ? div_w : mul_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work <= '0;
         opnd <= '0;
         op_q <= OP_MUL;
         ov_q <= 1'b0;
         cy_q <= 1'b0;
      end else begin
         if (adv) begin
            work <= nxt_work;
         end
         if (load) begin
            opnd <= cur_opnd;
            op_q <= cur_op;
         end
         if (last) begin
            cy_q <= 1'b0;
            ov_q <= (op_q == OP_DIV) ? (opnd == '0) : (mul_w[2*W-1:W] != '0);
         end
      end
   end

   assign a_out   = work[W-1:0];
   assign b_out   = work[2*W-1:W];
   assign cy_out  = cy_q;
   assign ov_out  = ov_q;
   assign par_out = ^work[W-1:0];

   // R3: carry reads cleared whenever results are announced
   p_carry_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cy_out);

   // R4: multiply overflow agrees with the high result byte
   p_mul_ov_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_MUL) |-> (ov_out == (b_out != '0)));

   // R7: the unit is idle in the cycle results are announced
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: idle with no launch keeps every result still
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(a_out) && $stable(b_out) && $stable(ov_out)
                            && $stable(cy_out));
endmodule

// File: tb/md8_unit_bench.sv
module md8_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       op_div = 1'b0;
   logic [7:0] a_in = '0;
   logic [7:0] b_in = '0;
   logic       busy, done, cy_out, ov_out, par_out;
   logic [7:0] a_out, b_out;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   md8_unit u_md8_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
      .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
      .a_out(a_out), .b_out(b_out), .cy_out(cy_out), .ov_out(ov_out),
      .par_out(par_out)
   );

   // behavioural reference model
   int cnt_m = 0;
   bit done_m = 0;
   bit op_m = 0;
   bit any_op = 0;
   bit skip_ab = 0;
   int exp_a = 0, exp_b = 0, exp_ov = 0;
   int pa = 0, pb = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         cnt_m = 0; done_m = 0; any_op = 0; skip_ab = 0;
         exp_a = 0; exp_b = 0; exp_ov = 0;
      end else begin
         done_m = 0;
         if (cnt_m == 0) begin
            if (start) begin
               cnt_m = 1; op_m = op_div; pa = a_in; pb = b_in;
            end
         end else if (cnt_m == 3) begin
            cnt_m = 0; done_m = 1; any_op = 1;
            if (!op_m) begin
               exp_a = (pa * pb) % 256; exp_b = (pa * pb) / 256;
               exp_ov = ((pa * pb) > 255) ? 1 : 0; skip_ab = 0;
            end else if (pb == 0) begin
               exp_ov = 1; skip_ab = 1;
            end else begin
               exp_a = pa / pb; exp_b = pa % pb; exp_ov = 0; skip_ab = 0;
            end
         end else begin
            cnt_m = cnt_m + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare on every clock, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         string vt, ot;
         vt = !any_op ? "R9" : (done_m ? (op_m ? "R2" : "R1") : "R10");
         ot = !any_op ? "R9" : (op_m ? "R5" : "R4");
         chk(done === done_m, "R7 done", int'(done), int'(done_m));
         chk(busy === (cnt_m != 0), "R7 busy", int'(busy), int'(cnt_m != 0));
         chk(par_out === ^a_out, "R6 parity", int'(par_out), int'(^a_out));
         if (cnt_m == 0) begin
            if (!skip_ab) begin
               chk(a_out === 8'(exp_a), {vt, " a_out"}, int'(a_out), exp_a);
               chk(b_out === 8'(exp_b), {vt, " b_out"}, int'(b_out), exp_b);
            end
            chk(ov_out === 1'(exp_ov), {ot, " ov_out"}, int'(ov_out), exp_ov);
            chk(cy_out === 1'b0, "R3 cy_out", int'(cy_out), 0);
         end
      end
   end

   task automatic go(input bit dv, input int a, input int b);
      @(negedge clk);
      start = 1'b1; op_div = dv; a_in = 8'(a); b_in = 8'(b);
      @(negedge clk);
      start = 1'b0; a_in = '0; b_in = '0;
   endtask

   task automatic run(input bit dv, input int a, input int b);
      go(dv, a, b);
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!busy && !done && a_out == 0 && b_out == 0 && !ov_out && !cy_out && !par_out,
          "R9 reset", int'({busy, done, ov_out, cy_out, par_out}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run(0, 8'h00, 8'h55);            // R1 zero product
      run(0, 8'hFF, 8'hFF);            // R1 R4 largest product
      run(0, 12, 20);                  // R4 fits in a byte
      run(0, 16, 16);                  // R4 exactly 256
      run(1, 200, 7);                  // R2
      run(1, 255, 1);                  // R2
      run(1, 5, 9);                    // R2 divisor larger
      run(1, 100, 0);                  // R5 zero divisor
      run(1, 255, 255);                // R2
      // R10: back-to-back start in the done cycle
      go(0, 8'hAB, 8'hCD);
      repeat (2) @(negedge clk);
      go(1, 8'hF0, 8'h0D);
      repeat (5) @(negedge clk);
      // R8: start pulse in the middle of an operation is ignored
      go(0, 8'h21, 8'h13);
      @(negedge clk);
      start = 1'b1; op_div = 1'b1; a_in = 8'h07; b_in = 8'h00;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      run(0, 8'h81, 8'h02);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired R7 actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule